// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block sits between two independent access ports and a shared dual-port storage array. Each port presents a chip enable, a write strobe and an address. When both ports are enabled on the same address, the block picks one winner and raises a busy flag to the other port. While that flag is active, the losing port's write strobe toward the array is suppressed. Its read strobe still passes, and the flag is returned with the data.

A strap input selects the operating role. With the strap high, the block runs its own arbitration and presents the result on the busy outputs. With the strap low, the local arbiter is bypassed and the busy outputs follow two external busy inputs. Several devices can then be placed side by side for a wider word: one device decides, and the others accept its decision.

Arbitration is clocked. A port that is already holding an address keeps it against a port that arrives later. When both ports arrive in the same cycle, the left port wins. A winner keeps the grant for as long as both ports stay on the same address.

Top module: `dp_busy_arbiter`

## Requirements
- R1: After reset, with both chip enables low, both busy outputs are low and no memory strobe is active.
- R2: In master mode, with no address match in the current cycle and none in the previous cycle, both busy outputs are low.
- R3: In master mode, at most one busy output is high in any cycle.
- R4: In master mode, if both ports become enabled on an equal address in the same cycle and neither held that address in the previous cycle, the left port wins and `r_busy` goes high.
- R5: In master mode, a port that arrives on an address the other port held in the previous cycle loses and sees busy. A port holds an address when it was enabled on that same address.
- R6: In master mode, the winner keeps the grant in every following cycle in which both ports stay enabled on unchanged, equal addresses.
- R7: In master mode, the loser's busy stays high for exactly one cycle after the match ends, then drops.
- R8: A port's memory write strobe is high only when its chip enable and write strobe are high and its busy is low. In master mode, the two ports never both write during a match.
- R9: In slave mode (`master` low), `l_busy` and `r_busy` equal `l_busy_in` and `r_busy_in`, and the local arbiter has no effect.
- R10: A port's memory read strobe is its chip enable with its write strobe low, regardless of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | Role strap: 1 = local arbitration, 0 = follow external busy |
| l_ce | input | 1 | Left port chip enable |
| l_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_addr | input | AW | Left port address |
| r_ce | input | 1 | Right port chip enable |
| r_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_addr | input | AW | Right port address |
| l_busy_in | input | 1 | External busy for the left port (slave mode) |
| r_busy_in | input | 1 | External busy for the right port (slave mode) |
| l_busy | output | 1 | Busy flag to the left port |
| r_busy | output | 1 | Busy flag to the right port |
| l_mem_we | output | 1 | Gated left write strobe to the array |
| r_mem_we | output | 1 | Gated right write strobe to the array |
| l_mem_re | output | 1 | Left read strobe to the array |
| r_mem_re | output | 1 | Right read strobe to the array |

## Verification
The bench covers several cases:
- Both ports arrive on the same address in the same cycle. A design that favoured the right port, or flagged both ports, fails here.
- The right port holds an address and the left port arrives later. A design that always favoured the left port would let the late writer corrupt the location.
- The holder moves to a new address and the other port follows it there.
- A contention ends. A design that dropped busy at once, or held it for two cycles, fails the one-cycle release check.
- A loser is reading while busy. A design that also blocked reads fails here.
- The device is in slave mode with an address match present. A design that let the local arbiter leak through would raise busy there.

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_in,
  input  logic          r_busy_in,
  output logic          l_busy,
  output logic          r_busy,
  output logic          l_mem_we,
  output logic          r_mem_we,
  output logic          l_mem_re,
  output logic          r_mem_re
);

  typedef enum logic [1:0] {OWN_NONE, OWN_L, OWN_R} own_t;

  own_t          own_q;
  logic          l_ce_q, r_ce_q, l_hold_q, r_hold_q;
  logic [AW-1:0] l_addr_q, r_addr_q;

  wire match  = l_ce && r_ce && (l_addr == r_addr);
  wire l_held = l_ce_q && (l_addr_q == l_addr);
  wire r_held = r_ce_q && (r_addr_q == r_addr);
  wire keep   = (own_q != OWN_NONE) && l_held && r_held;
  wire win_r  = keep ? (own_q == OWN_R) : (r_held && !l_held);
  wire l_lose = match && win_r;
  wire r_lose = match && !win_r;

  wire loc_l_busy = match ? l_lose : l_hold_q;
  wire loc_r_busy = match ? r_lose : r_hold_q;

  assign l_busy   = master ? loc_l_busy : l_busy_in;
  assign r_busy   = master ? loc_r_busy : r_busy_in;
  assign l_mem_we = l_ce && l_we && !l_busy;
  assign r_mem_we = r_ce && r_we && !r_busy;
  assign l_mem_re = l_ce && !l_we;
  assign r_mem_re = r_ce && !r_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q    <= OWN_NONE;
      l_ce_q   <= 1'b0;
      r_ce_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_hold_q <= 1'b0;
      r_hold_q <= 1'b0;
    end else begin
      own_q    <= (master && match) ? (win_r ? OWN_R : OWN_L) : OWN_NONE;
      l_ce_q   <= l_ce;
      r_ce_q   <= r_ce;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_hold_q <= master && l_lose;
      r_hold_q <= master && r_lose;
    end
  end

  a_r3_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> $onehot0({l_busy, r_busy}));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && !match && !$past(match) |-> !l_busy && !r_busy);

  a_r4_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
    master && match && !$past(l_ce) && !$past(r_ce) |-> r_busy && !l_busy);

  a_r6_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && match && $past(match) && $stable(l_addr) && $stable(r_addr)
      && $past(r_busy) |-> r_busy);

  a_r7_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && $past(match) && !match && $past(l_busy) |-> l_busy);

  a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    master && match |-> !(l_mem_we && r_mem_we));

endmodule

// File: tb/test_dp_busy_arbiter.sv
module test_dp_busy_arbiter;
  localparam int AW = 17;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0, l_busy_in = 0, r_busy_in = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy, r_busy, l_mem_we, r_mem_we, l_mem_re, r_mem_re;

  always #4 clk = ~clk;

  dp_busy_arbiter #(.AW(AW)) i_dp_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .master(master),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy(l_busy), .r_busy(r_busy),
    .l_mem_we(l_mem_we), .r_mem_we(r_mem_we),
    .l_mem_re(l_mem_re), .r_mem_re(r_mem_re));

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  task automatic drive(input logic m, input logic lc, input logic lw, input int la,
                       input logic rc, input logic rw, input int ra,
                       input logic bli, input logic bri,
                       input logic [5:0] ev, input string tag);
    exp_t e;
    @(negedge clk);
    master = m; l_ce = lc; l_we = lw; l_addr = AW'(la);
    r_ce = rc; r_we = rw; r_addr = AW'(ra);
    l_busy_in = bli; r_busy_in = bri;
    e.v = ev; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        e = q.pop_front();
        act = {l_busy, r_busy, l_mem_we, r_mem_we, l_mem_re, r_mem_re};
        n_run++;
        if (act !== e.v) begin
          n_fail++;
          $display("FAIL %s: {lb,rb,lw,rw,lr,rr} actual %b expected %b", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // expected vector: {l_busy, r_busy, l_mem_we, r_mem_we, l_mem_re, r_mem_re}
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    drive(1,0,0,0, 0,0,0, 0,0, 6'b000000, "R1 reset idle");
    drive(1,1,1,5, 1,1,9, 0,0, 6'b001100, "R2 R8 distinct addresses");
    drive(1,1,1,7, 1,1,7, 0,0, 6'b011000, "R4 tie goes left");
    drive(1,1,1,7, 1,1,7, 0,0, 6'b011000, "R6 grant kept");
    drive(1,1,1,7, 0,0,7, 0,0, 6'b011000, "R7 hold one cycle");
    drive(1,1,1,7, 0,0,0, 0,0, 6'b001000, "R7 released");
    drive(1,0,0,0, 1,1,3, 0,0, 6'b000100, "R2 right alone");
    drive(1,1,1,3, 1,1,3, 0,0, 6'b100100, "R5 late left loses");
    drive(1,1,0,3, 1,1,3, 0,0, 6'b100110, "R10 loser read passes");
    drive(1,1,1,3, 1,1,4, 0,0, 6'b100100, "R7 R8 hold blocks write");
    drive(1,1,1,4, 1,1,4, 0,0, 6'b100100, "R5 follower loses again");
    drive(1,0,0,0, 0,0,0, 0,0, 6'b100000, "R7 hold after both leave");
    drive(1,0,0,0, 0,0,0, 0,0, 6'b000000, "R7 drop");
    drive(0,1,1,8, 1,1,8, 1,0, 6'b100100, "R9 slave left busy");
    drive(0,1,1,8, 1,1,8, 0,0, 6'b001100, "R9 slave bypasses arbiter");
    drive(0,1,1,1, 1,1,2, 0,1, 6'b011000, "R9 slave right busy");
    drive(1,0,0,0, 0,0,0, 0,0, 6'b000000, "R3 back to master idle");
    drive(1,1,1,2, 1,1,2, 0,0, 6'b011000, "R3 R4 tie after slave");
    drive(1,0,0,0, 1,1,2, 0,0, 6'b010000, "R7 right hold blocks write");
    drive(1,1,0,2, 0,0,0, 0,0, 6'b000010, "R10 R2 plain read");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule